// File: doc/BRIEF.md
# Framed Serial Register Loader

This block takes 16-bit command words from a three-wire serial port (serial clock, active-low frame strobe, data) and turns them into the tuning and mode registers read by an oscillator core running on a separate master clock. Bits are captured on the falling serial clock edge, most significant first, while the frame strobe is low. A finished word raises a toggle in the serial domain. A synchronizer in the master domain turns that toggle into a single-cycle write strobe, and the register bank acts on it.

Wide registers are not written directly. A payload byte first lands in the low byte of a 16-bit staging register. A second word then supplies the high byte, and the whole 16-bit value goes into one half-word of a frequency or phase register in the same master cycle. The core therefore never sees a half-written half-word. Two separate word types set the select bits and the control bits.

Top module: `serial_reg_loader`

## Requirements
- R1: A word is 16 bits sent most significant bit first, captured on falling serial clock edges while the frame strobe is low. Bits 15:12 are the opcode, bits 11:8 the address and bits 7:0 the data.
- R2: If the frame strobe rises before the 16th bit has arrived, the partial word is dropped. No register changes and no write strobe is raised. The next full frame is decoded normally.
- R3: Bits clocked after the 16th bit in the same frame are ignored. A frame yields at most one write.
- R4: Every completed word gives exactly one write strobe `wr_o`, high for one master cycle. The registers take the new value on the master edge at which that strobe is high.
- R5: Opcode 0000 places the data byte in the low byte of the staging register. No output changes.
- R6: Opcode 0001 writes the 16-bit value {data, staged low byte} to half-word target address[3:1], and address bit 0 has no effect. Targets 0 and 1 are the low and high halves of frequency register 0. Targets 2 and 3 are the low and high halves of frequency register 1. Targets 4 to 7 are phase registers 0 to 3, each of which keeps the low 12 bits.
- R7: A commit to one half of a frequency register leaves its other half unchanged.
- R8: Opcode 1000 sets the select bits: data bit 0 is the frequency select and data bits 2:1 are the phase select.
- R9: Opcode 1100 sets the control bits: data bit 0 is select-source, data bit 1 is sync and data bit 2 is power-down.
- R10: A word with any other opcode changes no output.
- R11: Reset clears all frequency, phase, select and control outputs to zero.
- R12: The staged low byte persists after a commit and is reused by later commits until it is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset. It must also span a few falling serial clock edges. |
| sclk | input | 1 | Serial clock; data is captured on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdata | input | 1 | Serial data, most significant bit first |
| wr_o | output | 1 | One-cycle write strobe in the master domain |
| freq_o | output | NUM_FREQ*FREQ_W (64) | Frequency registers, with register 0 in the low bits |
| phase_o | output | NUM_PHASE*PHASE_W (48) | Phase registers, with register 0 in the low bits |
| fsel_o | output | 1 | Frequency select bit |
| psel_o | output | 2 | Phase select bits |
| sel_src_o | output | 1 | Control: select-source bit |
| sync_o | output | 1 | Control: sync bit |
| pwrdn_o | output | 1 | Control: power-down bit |

## Verification
The bench builds the block with its default parameters: two 32-bit frequency registers, four 12-bit phase registers and a two-stage synchronizer. With these values all eight half-word commit targets are addressable from the 4-bit address field, so every target, including the truncated phase halves, is written and read back at least once. The serial clock is run well below the master clock, so each word's strobe appears and is counted before the next frame begins. The cases covered are short and long frames, reuse of the staged byte, and writes to only one half of a register.

// File: rtl/srl_pkg.sv
package srl_pkg;

    localparam int WORD_W = 16;
    localparam int HALF_W = 16;

    typedef enum logic [3:0] {
        OP_STAGE_LO = 4'h0,
        OP_COMMIT   = 4'h1,
        OP_SELECT   = 4'h8,
        OP_CONTROL  = 4'hC
    } op_e;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] addr;
        logic [7:0] data;
    } cmd_t;

    typedef struct packed {
        logic [1:0] psel;
        logic       fsel;
    } sel_t;

    typedef struct packed {
        logic pwrdn;
        logic sync;
        logic sel_src;
    } ctl_t;

    function automatic logic [3:0] half_index(input logic [3:0] addr);
        return addr >> 1;
    endfunction

endpackage

// File: rtl/srl_shift.sv
module srl_shift
    import srl_pkg::*;
(
    input  logic              rst,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdata,
    output logic [WORD_W-1:0] word_o,
    output logic              tog_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-2:0] sh;

    // Raising the frame strobe clears the counter at once, so a partial word is lost.
    always_ff @(negedge sclk or posedge fsync_n) begin
        if (fsync_n)          cnt <= '0;
        else if (rst)         cnt <= '0;
        else if (cnt != FULL) cnt <= cnt + 1'b1;
    end

    always_ff @(negedge sclk) begin
        sh <= {sh[WORD_W-3:0], sdata};
    end

    always_ff @(negedge sclk) begin
        if (rst) begin
            word_o <= '0;
            tog_o  <= 1'b0;
        end else if (!fsync_n && cnt == LAST) begin
            word_o <= {sh, sdata};
            tog_o  <= ~tog_o;
        end
    end

    // R3: the counter stops at the word length
    a_r3_count_bound: assert property (@(negedge sclk) disable iff (rst)
        cnt <= FULL);

    // R2: the toggle flips only when a 16th bit is taken inside a frame
    a_r2_toggle_only_on_full: assert property (@(negedge sclk) disable iff (rst)
        (fsync_n || cnt != LAST) |=> $stable(tog_o));

endmodule

// File: rtl/srl_sync.sv
module srl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_i,
    output logic wr_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], tog_i};
    end

    assign wr_o = chain[STAGES] ^ chain[STAGES-1];

    // R4: the write strobe lasts a single master cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);

endmodule

// File: rtl/srl_regs.sv
module srl_regs
    import srl_pkg::*;
#(
    parameter int NUM_FREQ  = 2,
    parameter int FREQ_W    = 32,
    parameter int NUM_PHASE = 4,
    parameter int PHASE_W   = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_i,
    input  logic [WORD_W-1:0]             word_i,
    output logic [NUM_FREQ*FREQ_W-1:0]    freq_o,
    output logic [NUM_PHASE*PHASE_W-1:0]  phase_o,
    output sel_t                          sel_o,
    output ctl_t                          ctl_o
);
    localparam int FH     = FREQ_W / HALF_W;
    localparam int NUM_FH = NUM_FREQ * FH;

    cmd_t              cmd;
    logic [3:0]        tgt;
    logic [HALF_W-1:0] val;
    logic [7:0]        stage_lo;
    logic              commit;
    logic [HALF_W-1:0] half_q [NUM_FH];
    logic [PHASE_W-1:0] ph_q  [NUM_PHASE];

    assign cmd    = cmd_t'(word_i);
    assign tgt    = half_index(cmd.addr);
    assign val    = {cmd.data, stage_lo};
    assign commit = wr_i && (cmd.op == OP_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            sel_o    <= '0;
            ctl_o    <= '0;
        end else if (wr_i) begin
            case (cmd.op)
                OP_STAGE_LO: stage_lo <= cmd.data;
                OP_SELECT:   sel_o    <= '{psel: cmd.data[2:1], fsel: cmd.data[0]};
                OP_CONTROL:  ctl_o    <= '{pwrdn: cmd.data[2], sync: cmd.data[1],
                                           sel_src: cmd.data[0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int t = 0; t < NUM_FH; t++) begin
            if (rst)                            half_q[t] <= '0;
            else if (commit && tgt == 4'(t))    half_q[t] <= val;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PHASE; p++) begin
            if (rst)                                   ph_q[p] <= '0;
            else if (commit && tgt == 4'(NUM_FH + p))  ph_q[p] <= val[PHASE_W-1:0];
        end
    end

    for (genvar f = 0; f < NUM_FREQ; f++) begin : g_freq
        for (genvar h = 0; h < FH; h++) begin : g_half
            assign freq_o[f*FREQ_W + h*HALF_W +: HALF_W] = half_q[f*FH + h];
        end
    end

    for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
        assign phase_o[p*PHASE_W +: PHASE_W] = ph_q[p];
    end

    // R10: outputs move only on a write strobe
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(freq_o) && $stable(phase_o) && $stable(sel_o) && $stable(ctl_o)));

    // R7: a commit to the low half of frequency 0 keeps its upper half
    a_r7_other_half_kept: assert property (@(posedge clk) disable iff (rst)
        (commit && tgt == 4'd0) |=> $stable(freq_o[FREQ_W-1:HALF_W]));

    // R8: select bits change only through the select opcode
    a_r8_select_only_by_op: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && cmd.op == OP_SELECT) |=> $stable(sel_o));

    // R9: control bits change only through the control opcode
    a_r9_control_only_by_op: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && cmd.op == OP_CONTROL) |=> $stable(ctl_o));

endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import srl_pkg::*;
#(
    parameter int NUM_FREQ    = 2,
    parameter int FREQ_W      = 32,
    parameter int NUM_PHASE   = 4,
    parameter int PHASE_W     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sclk,
    input  logic                         fsync_n,
    input  logic                         sdata,
    output logic                         wr_o,
    output logic [NUM_FREQ*FREQ_W-1:0]   freq_o,
    output logic [NUM_PHASE*PHASE_W-1:0] phase_o,
    output logic                         fsel_o,
    output logic [1:0]                   psel_o,
    output logic                         sel_src_o,
    output logic                         sync_o,
    output logic                         pwrdn_o
);
    logic [WORD_W-1:0] word;
    logic              tog;
    sel_t              sel;
    ctl_t              ctl;

    srl_shift u_shift (
        .rst     (rst),
        .sclk    (sclk),
        .fsync_n (fsync_n),
        .sdata   (sdata),
        .word_o  (word),
        .tog_o   (tog)
    );

    srl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .tog_i (tog),
        .wr_o  (wr_o)
    );

    srl_regs #(
        .NUM_FREQ  (NUM_FREQ),
        .FREQ_W    (FREQ_W),
        .NUM_PHASE (NUM_PHASE),
        .PHASE_W   (PHASE_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_o),
        .word_i  (word),
        .freq_o  (freq_o),
        .phase_o (phase_o),
        .sel_o   (sel),
        .ctl_o   (ctl)
    );

    assign fsel_o    = sel.fsel;
    assign psel_o    = sel.psel;
    assign sel_src_o = ctl.sel_src;
    assign sync_o    = ctl.sync;
    assign pwrdn_o   = ctl.pwrdn;

endmodule

// File: tb/serial_reg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_reg_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        fsync_n = 1'b1;
    logic        sdata = 1'b0;
    logic        wr_o;
    logic [63:0] freq_o;
    logic [47:0] phase_o;
    logic        fsel_o;
    logic [1:0]  psel_o;
    logic        sel_src_o, sync_o, pwrdn_o;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_reg_loader dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
        .wr_o(wr_o), .freq_o(freq_o), .phase_o(phase_o), .fsel_o(fsel_o),
        .psel_o(psel_o), .sel_src_o(sel_src_o), .sync_o(sync_o), .pwrdn_o(pwrdn_o)
    );

    always @(negedge clk) if (wr_o === 1'b1) pulses++;

    // {word, observed field, expected}; field 0..1 freq, 2..5 phase, 6 {psel,fsel}, 7 {pwrdn,sync,sel_src}
    localparam int NV = 18;
    localparam logic [50:0] TBL [NV] = '{
        {16'h0034, 3'd0, 32'h0000_0000},  // R5 staging only
        {16'h1012, 3'd0, 32'h0000_1234},  // R6 freq0 low
        {16'h00CD, 3'd0, 32'h0000_1234},  // R5
        {16'h13AB, 3'd0, 32'hABCD_1234},  // R6 R7 freq0 high, addr bit0 set
        {16'h0078, 3'd1, 32'h0000_0000},  // R5
        {16'h1456, 3'd1, 32'h0000_5678},  // R6 freq1 low
        {16'h1799, 3'd1, 32'h9978_5678},  // R12 staged byte reused, R7
        {16'h00F1, 3'd2, 32'h0000_0000},  // R5
        {16'h18AF, 3'd2, 32'h0000_0FF1},  // R6 phase0, 12 bits kept
        {16'h1F0B, 3'd5, 32'h0000_0BF1},  // R6 phase3
        {16'h1A12, 3'd3, 32'h0000_02F1},  // R6 phase1
        {16'h1C03, 3'd4, 32'h0000_03F1},  // R6 phase2
        {16'h8005, 3'd6, 32'h0000_0005},  // R8
        {16'hC006, 3'd7, 32'h0000_0006},  // R9
        {16'h3FFF, 3'd0, 32'hABCD_1234},  // R10
        {16'h5FFF, 3'd7, 32'h0000_0006},  // R10
        {16'hF0FF, 3'd1, 32'h9978_5678},  // R10
        {16'h8002, 3'd6, 32'h0000_0002}   // R8
    };

    function automatic logic [31:0] observe(input logic [2:0] k);
        case (k)
            3'd0: return freq_o[31:0];
            3'd1: return freq_o[63:32];
            3'd2: return {20'd0, phase_o[11:0]};
            3'd3: return {20'd0, phase_o[23:12]};
            3'd4: return {20'd0, phase_o[35:24]};
            3'd5: return {20'd0, phase_o[47:36]};
            3'd6: return {29'd0, psel_o, fsel_o};
            default: return {29'd0, pwrdn_o, sync_o, sel_src_o};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        pulses = 0;
        fsync_n = 1'b0;
        #10;
        for (int i = n - 1; i >= 0; i--) begin
            sdata = bits[i];
            #10 sclk = 1'b0;
            #20 sclk = 1'b1;
            #10;
        end
        fsync_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fsync_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #10 sclk = 1'b0;
            #10 sclk = 1'b1;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all_zero(input string req);
        check(req, freq_o, 64'd0);
        check(req, {16'd0, phase_o}, 64'd0);
        check(req, {59'd0, psel_o, fsel_o, pwrdn_o, sync_o, sel_src_o}, 64'd0);
    endtask

    initial begin
        do_reset();
        check_all_zero("R11 after reset");

        // R1 R4: each table word, MSB first, one strobe, then the observed field
        for (int v = 0; v < NV; v++) begin
            send({16'd0, TBL[v][50:35]}, 16);
            check("R4 strobe count", 64'(pulses), 64'd1);
            check(TBL[v][34:32] < 3'd6 ? "R6 table" : (TBL[v][34:32] == 3'd6 ? "R8 table" : "R9 table"),
                  {32'd0, observe(TBL[v][34:32])}, {32'd0, TBL[v][31:0]});
        end

        // R2: aborted frame after ten bits
        send({16'd0, 16'hC001} >> 6, 10);
        check("R2 no strobe", 64'(pulses), 64'd0);
        check("R2 control kept", {32'd0, observe(3'd7)}, 64'd6);
        send({16'd0, 16'hC001}, 16);
        check("R2 next frame decoded", {32'd0, observe(3'd7)}, 64'd1);

        // R3: four extra bits in the frame are ignored
        send({12'd0, 16'h8007, 4'hF}, 20);
        check("R3 one strobe", 64'(pulses), 64'd1);
        check("R3 select", {32'd0, observe(3'd6)}, 64'd7);

        // R11: reset in mid-run clears everything
        do_reset();
        check_all_zero("R11 mid-run reset");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule